// File: doc/BRIEF.md
# Serial Bus Stuck-Line Timeout Monitor

This block sits beside the slave state machine of a two-wire serial interface. It watches the already-synchronized clock and data line levels. While a transfer to this slave is in progress and the timeout feature is switched on, it measures how long the bus has gone without both lines returning high. If the clock line or the data line stays low for longer than the configured number of cycles, it raises a single-cycle reset pulse. The slave interface uses that pulse to let go of the data line and go back to waiting for a fresh START condition.

The timeout length is the parameter `TIMEOUT_CYCLES`, given in core clock cycles. Together with `CLK_HZ`, it must describe a window of 30 ms to 60 ms. Elaboration stops with an error if the value falls outside that window. The enable bit comes from the configuration register bank and is set by reset. The transfer-busy flag comes from the slave state machine and is high from an accepted START until the transfer ends. A STOP leaves both lines high, so the low-time count is dropped. Resetting any register outside the serial interface is left to the surrounding logic.

Top module: `stall_timeout_monitor`

## Requirements
- R1: While `rst` is high, `iface_rst` is 0. After `rst` falls, a stall must again last the full timeout before any pulse.
- R2: With `tmo_en`=1 and `xfer_busy`=1, `iface_rst` rises in the cycle after the (TIMEOUT_CYCLES+1)-th consecutive clock edge at which at least one line was sampled low. A run of only TIMEOUT_CYCLES such edges produces no pulse. The pulse is exactly one cycle wide.
- R3: A stall with `scl_lvl`=1 and `sda_lvl`=0 counts in the same way as a stall with `scl_lvl`=0.
- R4: A stall produces exactly one pulse, however long it lasts. Once both lines have been sampled high, a new stall can fire again.
- R5: Any edge at which both lines are sampled high clears the low-time count. The next stall needs the full count again. This includes the high-high state that a STOP leaves behind.
- R6: While `tmo_en`=0 no pulse is produced, however long the lines stay low.
- R7: While `xfer_busy`=0 no pulse is produced, and the low-time count is cleared.
- R8: A single edge with `tmo_en`=0 in the middle of a stall clears the count at once. After the bit is set again, the full count is needed before a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tmo_en | input | 1 | Timeout enable bit from the configuration registers |
| xfer_busy | input | 1 | High while the slave state machine is inside a valid transfer |
| scl_lvl | input | 1 | Synchronized serial clock line level |
| sda_lvl | input | 1 | Synchronized serial data line level |
| iface_rst | output | 1 | One-cycle pulse that resets the slave interface |

## Verification
A low-time count that is wrong by even one cycle shows at the port as a pulse one cycle early or late. The bench compares the output at every cycle against its own model, so such an error is caught at the edge where the pulse should have risen, or should not have. A count that is not cleared shows up as an early pulse on the stall that follows. A saturation state that does not hold appears as a second pulse during a long stall, at most TIMEOUT_CYCLES+1 cycles after the first.

// File: rtl/stall_tmo_pkg.sv
package stall_tmo_pkg;

    typedef enum logic [1:0] {
        TMR_IDLE  = 2'd0,
        TMR_RUN   = 2'd1,
        TMR_SPENT = 2'd2
    } tmr_state_t;

    typedef struct packed {
        logic armed;     // feature on and transfer in progress
        logic released;  // both lines sampled high
    } line_view_t;

    function automatic longint ms_to_cycles(input longint hz, input int ms);
        return (hz * longint'(ms)) / 64'd1000;
    endfunction

endpackage

// File: rtl/stm_line_decode.sv
module stm_line_decode
    import stall_tmo_pkg::*;
(
    input  logic       tmo_en,
    input  logic       xfer_busy,
    input  logic       scl_lvl,
    input  logic       sda_lvl,
    output line_view_t view
);

    always_comb begin
        view.armed    = tmo_en & xfer_busy;
        view.released = scl_lvl & sda_lvl;
    end

endmodule

// File: rtl/stm_stall_timer.sv
module stm_stall_timer
    import stall_tmo_pkg::*;
#(
    parameter int LIMIT = 400
) (
    input  logic       clk,
    input  logic       rst,
    input  line_view_t view,
    output logic       expire
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    tmr_state_t    state_q;
    logic [CW-1:0] cnt_q;
    logic          clear;

    assign clear = ~view.armed | view.released;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
            expire  <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (clear) begin
                state_q <= TMR_IDLE;
                cnt_q   <= '0;
            end else begin
                unique case (state_q)
                    TMR_IDLE, TMR_RUN: begin
                        if (cnt_q == LIM) begin
                            expire  <= 1'b1;
                            state_q <= TMR_SPENT;
                        end else begin
                            cnt_q   <= cnt_q + 1'b1;
                            state_q <= TMR_RUN;
                        end
                    end
                    default: state_q <= TMR_SPENT;
                endcase
            end
        end
    end

endmodule

// File: rtl/stall_timeout_monitor.sv
module stall_timeout_monitor
    import stall_tmo_pkg::*;
#(
    parameter int CLK_HZ         = 125_000_000,
    parameter int TIMEOUT_CYCLES = 5_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic tmo_en,
    input  logic xfer_busy,
    input  logic scl_lvl,
    input  logic sda_lvl,
    output logic iface_rst
);

    localparam longint WIN_LO = ms_to_cycles(longint'(CLK_HZ), 30);
    localparam longint WIN_HI = ms_to_cycles(longint'(CLK_HZ), 60);

    generate
        if (longint'(TIMEOUT_CYCLES) < WIN_LO || longint'(TIMEOUT_CYCLES) > WIN_HI) begin : g_bad_window
            $error("TIMEOUT_CYCLES lies outside the 30 ms to 60 ms window");
        end
    endgenerate

    line_view_t view;

    stm_line_decode u_decode (
        .tmo_en    (tmo_en),
        .xfer_busy (xfer_busy),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .view      (view)
    );

    stm_stall_timer #(
        .LIMIT (TIMEOUT_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .view   (view),
        .expire (iface_rst)
    );

endmodule

// File: rtl/stm_checker.sv
module stm_checker #(
    parameter int TIMEOUT_CYCLES = 400
) (
    input logic clk,
    input logic rst,
    input logic tmo_en,
    input logic xfer_busy,
    input logic scl_lvl,
    input logic sda_lvl,
    input logic iface_rst
);

    logic calm;
    int   low_run;
    logic seen_q;

    assign calm = ~(tmo_en & xfer_busy) | (scl_lvl & sda_lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run <= 0;
            seen_q  <= 1'b0;
        end else if (calm) begin
            low_run <= 0;
            seen_q  <= 1'b0;
        end else begin
            if (low_run <= TIMEOUT_CYCLES) low_run <= low_run + 1;
            seen_q <= seen_q | iface_rst;
        end
    end

    AST_PULSE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        iface_rst |=> !iface_rst); // R2
    AST_FULL_STALL_SEEN: assert property (@(posedge clk) disable iff (rst)
        iface_rst |-> (low_run == TIMEOUT_CYCLES + 1)); // R2
    AST_ONE_PER_STALL: assert property (@(posedge clk) disable iff (rst)
        iface_rst |-> !seen_q); // R4
    AST_QUIET_WHEN_HIGH: assert property (@(posedge clk) disable iff (rst)
        (scl_lvl && sda_lvl) |=> !iface_rst); // R5
    AST_QUIET_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !tmo_en |=> !iface_rst); // R6
    AST_QUIET_WHEN_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        !xfer_busy |=> !iface_rst); // R7

endmodule

bind stall_timeout_monitor stm_checker #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tmo_en    (tmo_en),
    .xfer_busy (xfer_busy),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .iface_rst (iface_rst)
);

// File: tb/test_stall_timeout_monitor.sv
module test_stall_timeout_monitor;

    localparam int CLK_HZ = 10_000;
    localparam int T      = 400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tmo_en = 1'b1;
    logic xfer_busy = 1'b0;
    logic scl_lvl = 1'b1;
    logic sda_lvl = 1'b1;
    logic iface_rst;

    int n_checks = 0;
    int n_fail   = 0;
    string tag   = "R1";

    int m_cnt   = 0;
    bit m_fired = 1'b0;
    bit m_pulse = 1'b0;

    always #4 clk = ~clk;

    stall_timeout_monitor #(
        .CLK_HZ         (CLK_HZ),
        .TIMEOUT_CYCLES (T)
    ) i_stall_timeout_monitor (
        .clk       (clk),
        .rst       (rst),
        .tmo_en    (tmo_en),
        .xfer_busy (xfer_busy),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .iface_rst (iface_rst)
    );

    function automatic bit is_calm(bit e, bit b, bit c, bit d);
        return !(e && b) || (c && d);
    endfunction

    task automatic tick(input bit r, input bit e, input bit b, input bit c, input bit d);
        rst = r; tmo_en = e; xfer_busy = b; scl_lvl = c; sda_lvl = d;
        @(posedge clk);
        if (r) begin
            m_cnt = 0; m_fired = 0; m_pulse = 0;
        end else begin
            m_pulse = 0;
            if (is_calm(e, b, c, d)) begin
                m_cnt = 0; m_fired = 0;
            end else if (!m_fired) begin
                if (m_cnt == T) begin
                    m_pulse = 1; m_fired = 1;
                end else begin
                    m_cnt++;
                end
            end
        end
        @(negedge clk);
        n_checks++;
        if (iface_rst !== m_pulse) begin
            n_fail++;
            $display("FAIL %s: iface_rst actual=%b expected=%b at %0t", tag, iface_rst, m_pulse, $time);
        end
    endtask

    task automatic run(input int n, input bit r, input bit e, input bit b,
                       input bit c, input bit d, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            tick(r, e, b, c, d);
            if (iface_rst === 1'b1) pulses++;
        end
    endtask

    task automatic expect_pulses(input int got, input int want, input string what);
        n_checks++;
        if (got != want) begin
            n_fail++;
            $display("FAIL %s: %s pulses actual=%0d expected=%0d", tag, what, got, want);
        end
    endtask

    initial begin : watchdog
        repeat (150_000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        int p, q;
        int seed;
        @(negedge clk);
        // R1: reset holds the output low even with a stalled, armed bus
        tag = "R1";
        run(3 * T, 1, 1, 1, 0, 0, p);
        expect_pulses(p, 0, "during reset");
        run(T, 0, 1, 1, 0, 0, p);
        expect_pulses(p, 0, "first T low edges after reset");
        run(2, 0, 1, 1, 0, 0, p);
        expect_pulses(p, 1, "edge T+1 after reset");
        run(3, 0, 1, 1, 1, 1, p);
        // R2: boundary, T low edges give nothing, T+1 give one pulse
        tag = "R2";
        run(T, 0, 1, 1, 0, 1, p);
        run(3, 0, 1, 1, 1, 1, q);
        expect_pulses(p + q, 0, "scl low for exactly T edges");
        run(T + 1, 0, 1, 1, 0, 1, p);
        run(2, 0, 1, 1, 1, 1, q);
        expect_pulses(p + q, 1, "scl low for T+1 edges");
        // R3: data line stuck low with clock high
        tag = "R3";
        run(T + 10, 0, 1, 1, 1, 0, p);
        expect_pulses(p, 1, "sda stuck low");
        run(2, 0, 1, 1, 1, 1, p);
        // R4: a long stall fires once, a later stall fires again
        tag = "R4";
        run(3 * T, 0, 1, 1, 0, 0, p);
        expect_pulses(p, 1, "long stall");
        run(2, 0, 1, 1, 1, 1, p);
        run(T + 2, 0, 1, 1, 0, 1, p);
        expect_pulses(p, 1, "stall after recovery");
        run(2, 0, 1, 1, 1, 1, p);
        // R5: a single high-high edge restarts the count
        tag = "R5";
        run(T - 50, 0, 1, 1, 0, 1, p);
        run(1, 0, 1, 1, 1, 1, q); p += q;
        run(T - 50, 0, 1, 1, 1, 0, q); p += q;
        expect_pulses(p, 0, "stall split by one high edge");
        run(2, 0, 1, 1, 1, 1, p);
        // R6: feature off
        tag = "R6";
        run(3 * T, 0, 0, 1, 0, 0, p);
        expect_pulses(p, 0, "enable off");
        // R7: no transfer in progress
        tag = "R7";
        run(3 * T, 0, 1, 0, 0, 1, p);
        expect_pulses(p, 0, "not busy");
        // R8: enable dropped for one edge mid-stall
        tag = "R8";
        run(T - 10, 0, 1, 1, 0, 0, p);
        run(1, 0, 0, 1, 0, 0, q); p += q;
        run(T - 10, 0, 1, 1, 0, 0, q); p += q;
        expect_pulses(p, 0, "stall split by enable drop");
        run(20, 0, 1, 1, 0, 0, p);
        expect_pulses(p, 1, "full count after re-enable");
        run(2, 0, 1, 1, 1, 1, p);
        // Random segments: R2 R3 R4 R5 R6 R7 per cycle against the model
        tag = "R2/R4 random";
        seed = $urandom(32'h5eed_1234);
        for (int s = 0; s < 80; s++) begin
            int len;
            bit e, b, c, d;
            len = 1 + int'($urandom_range(T + 60));
            e = ($urandom_range(9) != 0);
            b = ($urandom_range(7) != 0);
            c = $urandom_range(1);
            d = $urandom_range(1);
            run(len, 0, e, b, c, d, p);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule